// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This block adds or subtracts two 32-bit operands in one of four packed lane formats and registers the result. The formats are two unsigned 16-bit lanes with optional saturation, four unsigned 8-bit lanes with halving, two signed 16-bit lanes with halving, and one signed 32-bit lane with halving. One select input has two uses. In the unsigned 16-bit format it turns saturation on. In the three halving formats it adds one before the halving shift, which rounds the result.

The unsigned 16-bit format also keeps a sticky overflow flag. Any lane that carries out on an add, or borrows on a subtract, sets the flag. This happens whether or not saturation is on. The flag stays set until the clear input is asserted. A new overflow in the same cycle as the clear takes priority, so the flag stays set. The result and the flag appear one cycle after a valid input strobe, together with an output valid pulse.

Top module: `simd_addsub`

## Requirements
- R1: With fmt = 0 and sub = 0, each 16-bit lane adds as unsigned. If a lane sum exceeds 0xFFFF, that lane returns 0xFFFF when sat_rnd = 1. When sat_rnd = 0 it returns the low 16 bits of the sum.
- R2: With fmt = 0 and sub = 1, each 16-bit lane subtracts opb from opa. If a lane of opa is smaller than the same lane of opb, that lane returns 0x0000 when sat_rnd = 1. When sat_rnd = 0 it returns the wrapped difference.
- R3: An accepted operation with fmt = 0 in which any lane overflows or underflows sets ovf_flag, whatever the value of sat_rnd. Operations with fmt = 1, 2 or 3 never set ovf_flag.
- R4: ovf_flag stays set until ovf_clr is high on a clock edge. If ovf_clr is high on the same edge as an accepted overflowing operation, the flag stays set.
- R5: With fmt = 1, each 8-bit lane forms the 9-bit two's-complement sum or difference. It adds sat_rnd to that value, shifts right by one, and keeps the low 8 bits.
- R6: With fmt = 2, each 16-bit lane forms the full-precision signed sum or difference. It adds sat_rnd, shifts arithmetically right by one, and keeps the low 16 bits.
- R7: With fmt = 3, the unit forms the 33-bit signed sum or difference of the two words. It adds sat_rnd, shifts arithmetically right by one, and returns the low 32 bits.
- R8: Lanes are computed independently of each other, and lane 0 occupies the least significant bits of the result.
- R9: result, ovf_flag and out_valid update on the first clock edge after in_valid is sampled high. out_valid is low in every other cycle. result holds its value while no input is accepted.
- R10: While rst_n is low on a clock edge, out_valid, result and ovf_flag become zero on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accept strobe for the operands and selects |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand (subtrahend) |
| fmt | input | 2 | Lane format: 0 = unsigned 16-bit saturating, 1 = unsigned 8-bit halving, 2 = signed 16-bit halving, 3 = signed 32-bit halving |
| sub | input | 1 | 0 = add, 1 = subtract |
| sat_rnd | input | 1 | Saturate (fmt 0) or round (fmt 1 to 3) |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| out_valid | output | 1 | Result valid pulse |
| result | output | 32 | Registered packed result |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Every result, the overflow flag and the output valid pulse are due exactly one clock edge after the edge on which in_valid is sampled high. No output is due on any other edge. The bench changes inputs on the falling edge and drops in_valid on the next falling edge. It reads all three outputs at that point, half a period after the edge that captured them. It also reads them over idle cycles afterwards, to confirm that the result holds and the flag persists.

// File: rtl/simd_addsub_pkg.sv
// Package: shared lane-format encoding and derived widths for the packed
// SIMD add/subtract unit. Assumes a 32-bit word split into 16- and 8-bit lanes.
package simd_addsub_pkg;
    typedef enum logic [1:0] {
        FMT_U16_SAT  = 2'd0,
        FMT_U8_HALF  = 2'd1,
        FMT_S16_HALF = 2'd2,
        FMT_S32_HALF = 2'd3
    } lane_fmt_e;
endpackage

// File: rtl/simd_sat_lane.sv
// Unsigned saturating add/subtract lane of parameterised width.
// Reports carry-out (add) or borrow (sub) independently of saturation.
// Assumes unsigned operands; purely combinational.
module simd_sat_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         sat,
    output logic [W-1:0] y,
    output logic         ovf
);
    logic [W:0] sum_ext;
    logic [W:0] dif_ext;

    // Form the widened sum and difference, then select, flag and clamp.
    always_comb begin
        sum_ext = {1'b0, a} + {1'b0, b};
        dif_ext = {1'b0, a} - {1'b0, b};
        if (!sub) begin
            ovf = sum_ext[W];
            y   = (ovf && sat) ? {W{1'b1}} : sum_ext[W-1:0];
        end else begin
            ovf = (a < b);
            y   = (ovf && sat) ? {W{1'b0}} : dif_ext[W-1:0];
        end
    end
endmodule

// File: rtl/simd_half_lane.sv
// Halving add/subtract lane: forms the exact sum or difference in W+2 bits
// (sign- or zero-extended per SIGNED), adds the round bit, drops bit 0.
// Assumes the W+2 width cannot overflow, which holds for any W.
module simd_half_lane #(
    parameter int W      = 8,
    parameter bit SIGNED = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         rnd,
    output logic [W-1:0] y
);
    localparam int EW = W + 2;

    logic [EW-1:0] a_ext;
    logic [EW-1:0] b_ext;
    logic [EW-1:0] full;

    // Extend the operands according to the lane signedness.
    always_comb begin
        if (SIGNED) begin
            a_ext = {{2{a[W-1]}}, a};
            b_ext = {{2{b[W-1]}}, b};
        end else begin
            a_ext = {2'b00, a};
            b_ext = {2'b00, b};
        end
    end

    // Exact result plus rounding; the halved lane is the window above bit 0.
    always_comb begin
        full = (sub ? (a_ext - b_ext) : (a_ext + b_ext)) + {{(EW-1){1'b0}}, rnd};
        y    = full[W:1];
    end
endmodule

// File: rtl/simd_addsub.sv
// Packed SIMD add/subtract unit, top level.
// Computes all four lane formats in parallel, selects one by fmt, and
// registers the result, a valid pulse and a sticky overflow flag.
// Assumes WORD_W is a multiple of 16; synchronous active-low reset.
module simd_addsub
    import simd_addsub_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int HALF_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    input  logic [1:0]        fmt,
    input  logic              sub,
    input  logic              sat_rnd,
    input  logic              ovf_clr,
    output logic              out_valid,
    output logic [WORD_W-1:0] result,
    output logic              ovf_flag
);
    localparam int N_HALF = WORD_W / HALF_W;
    localparam int N_BYTE = WORD_W / BYTE_W;

    logic [WORD_W-1:0] u16_y;
    logic [N_HALF-1:0] u16_ovf;
    logic [WORD_W-1:0] u8_y;
    logic [WORD_W-1:0] s16_y;
    logic [WORD_W-1:0] s32_y;
    logic [WORD_W-1:0] sel_y;
    logic              ovf_now;

    // Unsigned saturating halfword lanes.
    for (genvar i = 0; i < N_HALF; i++) begin : g_u16
        simd_sat_lane #(.W(HALF_W)) u_lane (
            .a   (opa[i*HALF_W +: HALF_W]),
            .b   (opb[i*HALF_W +: HALF_W]),
            .sub (sub),
            .sat (sat_rnd),
            .y   (u16_y[i*HALF_W +: HALF_W]),
            .ovf (u16_ovf[i])
        );
    end

    // Unsigned halving byte lanes.
    for (genvar i = 0; i < N_BYTE; i++) begin : g_u8
        simd_half_lane #(.W(BYTE_W), .SIGNED(1'b0)) u_lane (
            .a   (opa[i*BYTE_W +: BYTE_W]),
            .b   (opb[i*BYTE_W +: BYTE_W]),
            .sub (sub),
            .rnd (sat_rnd),
            .y   (u8_y[i*BYTE_W +: BYTE_W])
        );
    end

    // Signed halving halfword lanes.
    for (genvar i = 0; i < N_HALF; i++) begin : g_s16
        simd_half_lane #(.W(HALF_W), .SIGNED(1'b1)) u_lane (
            .a   (opa[i*HALF_W +: HALF_W]),
            .b   (opb[i*HALF_W +: HALF_W]),
            .sub (sub),
            .rnd (sat_rnd),
            .y   (s16_y[i*HALF_W +: HALF_W])
        );
    end

    // Signed halving full-word lane.
    simd_half_lane #(.W(WORD_W), .SIGNED(1'b1)) u_s32 (
        .a   (opa),
        .b   (opb),
        .sub (sub),
        .rnd (sat_rnd),
        .y   (s32_y)
    );

    // Pick the lane set named by fmt; only the saturating format can overflow.
    always_comb begin
        unique case (lane_fmt_e'(fmt))
            FMT_U16_SAT:  sel_y = u16_y;
            FMT_U8_HALF:  sel_y = u8_y;
            FMT_S16_HALF: sel_y = s16_y;
            default:      sel_y = s32_y;
        endcase
        ovf_now = (lane_fmt_e'(fmt) == FMT_U16_SAT) && (|u16_ovf);
    end

    // Output register: valid pulse and result captured on an accepted input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= sel_y;
            end
        end
    end

    // Sticky overflow flag: a new overflow outranks a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (in_valid && ovf_now) begin
            ovf_flag <= 1'b1;
        end else if (ovf_clr) begin
            ovf_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/simd_addsub_chk.sv
// Checker for the packed SIMD add/subtract unit, bound to every instance.
// Observes only the top-level ports.
module simd_addsub_chk #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] opa,
    input logic [1:0]        fmt,
    input logic              sub,
    input logic              sat_rnd,
    input logic              ovf_clr,
    input logic              out_valid,
    input logic [WORD_W-1:0] result,
    input logic              ovf_flag
);
    // R10
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !ovf_flag && result == '0));

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R3
    flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(in_valid) && $past(fmt) == 2'd0));

    // R1
    sat_add_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt == 2'd0 && !sub && sat_rnd) |=>
        (result[15:0] >= $past(opa[15:0]) && result[31:16] >= $past(opa[31:16])));

    // R2
    sat_sub_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fmt == 2'd0 && sub && sat_rnd) |=>
        (result[15:0] <= $past(opa[15:0]) && result[31:16] <= $past(opa[31:16])));
endmodule

bind simd_addsub simd_addsub_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .opa       (opa),
    .fmt       (fmt),
    .sub       (sub),
    .sat_rnd   (sat_rnd),
    .ovf_clr   (ovf_clr),
    .out_valid (out_valid),
    .result    (result),
    .ovf_flag  (ovf_flag)
);

// File: tb/sim_simd_addsub.sv
// Bench for the packed SIMD add/subtract unit: a vector table walked by one
// loop, then directed tests for reset, flag persistence and clearing.
module sim_simd_addsub;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [1:0]  fmt = '0;
    logic        sub = 1'b0;
    logic        sat_rnd = 1'b0;
    logic        ovf_clr = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        ovf_flag;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct packed {
        logic [1:0]  f;
        logic        s;
        logic        r;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] y;
        logic        o;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b0, 32'h0001_8000, 32'h0002_9000, 32'h0003_1000, 1'b1},
        '{2'd0, 1'b0, 1'b1, 32'h0001_8000, 32'h0002_9000, 32'h0003_FFFF, 1'b1},
        '{2'd0, 1'b1, 1'b0, 32'h0005_0003, 32'h0002_0004, 32'h0003_FFFF, 1'b1},
        '{2'd0, 1'b1, 1'b1, 32'h0005_0003, 32'h0002_0004, 32'h0003_0000, 1'b1},
        '{2'd0, 1'b0, 1'b1, 32'h1234_0001, 32'h0001_0002, 32'h1235_0003, 1'b0},
        '{2'd0, 1'b0, 1'b1, 32'hFFFF_0001, 32'h0001_0001, 32'hFFFF_0002, 1'b1},
        '{2'd1, 1'b0, 1'b0, 32'hFF01_8003, 32'h0101_8000, 32'h8001_8001, 1'b0},
        '{2'd1, 1'b0, 1'b1, 32'hFF01_8003, 32'h0101_8000, 32'h8001_8002, 1'b0},
        '{2'd1, 1'b1, 1'b0, 32'h0010_0500, 32'h0108_0200, 32'hFF04_0100, 1'b0},
        '{2'd1, 1'b1, 1'b1, 32'h0010_0500, 32'h0108_0200, 32'h0004_0200, 1'b0},
        '{2'd2, 1'b0, 1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFE, 32'h7FFF_FFFE, 1'b0},
        '{2'd2, 1'b0, 1'b1, 32'h7FFF_FFFF, 32'h7FFF_FFFE, 32'h7FFF_FFFF, 1'b0},
        '{2'd2, 1'b1, 1'b0, 32'h8000_0003, 32'h7FFF_0005, 32'h8000_FFFF, 1'b0},
        '{2'd3, 1'b0, 1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFE, 32'h7FFF_FFFE, 1'b0},
        '{2'd3, 1'b0, 1'b1, 32'h7FFF_FFFF, 32'h7FFF_FFFE, 32'h7FFF_FFFF, 1'b0},
        '{2'd3, 1'b1, 1'b1, 32'h8000_0000, 32'h0000_0001, 32'hC000_0000, 1'b0}
    };

    simd_addsub u0 (
        .clk, .rst_n, .in_valid, .opa, .opb, .fmt, .sub, .sat_rnd, .ovf_clr,
        .out_valid, .result, .ovf_flag
    );

    always #4 clk = ~clk;

    function automatic string tag_of(input logic [1:0] f, input logic s);
        if (f == 2'd0) return s ? "R2" : "R1";
        if (f == 2'd1) return "R5";
        if (f == 2'd2) return "R6";
        return "R7";
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Present one operation on a falling edge; outputs are read one edge later.
    task automatic issue(input logic [1:0] f, input logic s, input logic r,
                         input logic [31:0] a, input logic [31:0] b, input logic clr);
        @(negedge clk);
        in_valid = 1'b1; fmt = f; sub = s; sat_rnd = r; opa = a; opb = b; ovf_clr = clr;
        @(negedge clk);
        in_valid = 1'b0; ovf_clr = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "out_valid in reset", {31'b0, out_valid}, 32'd0);
        check("R10", "result in reset", result, 32'd0);
        check("R10", "flag in reset", {31'b0, ovf_flag}, 32'd0);
        rst_n = 1'b1;

        // Table: each vector clears the flag in the same cycle, so the flag
        // afterwards equals this vector's own overflow (R3, R4 priority).
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].f, VECS[i].s, VECS[i].r, VECS[i].a, VECS[i].b, 1'b1);
            check(tag_of(VECS[i].f, VECS[i].s), $sformatf("vector %0d result", i),
                  result, VECS[i].y);
            check("R3", $sformatf("vector %0d flag", i), {31'b0, ovf_flag}, {31'b0, VECS[i].o});
            check("R9", $sformatf("vector %0d valid", i), {31'b0, out_valid}, 32'd1);
        end

        // R8: independent lanes, lane 0 at the least significant end.
        issue(2'd0, 1'b0, 1'b1, 32'h0001_FFFF, 32'h0001_0001, 1'b1);
        check("R8", "lane 0 saturates alone", result, 32'h0002_FFFF);

        // R9: hold across idle cycles; R4: flag persists without clear.
        repeat (3) @(negedge clk);
        check("R9", "valid low when idle", {31'b0, out_valid}, 32'd0);
        check("R9", "result held when idle", result, 32'h0002_FFFF);
        check("R4", "flag persists", {31'b0, ovf_flag}, 32'd1);

        // R3: a non-overflow op without clear leaves the flag set.
        issue(2'd1, 1'b0, 1'b0, 32'h0202_0202, 32'h0202_0202, 1'b0);
        check("R5", "byte halving of equal lanes", result, 32'h0202_0202);
        check("R4", "flag kept without clear", {31'b0, ovf_flag}, 32'd1);

        // R4: clear on its own.
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        check("R4", "clear alone", {31'b0, ovf_flag}, 32'd0);
        check("R9", "result held through clear", result, 32'h0202_0202);

        // R3: overflow without saturation still raises the flag.
        issue(2'd0, 1'b1, 1'b0, 32'h0000_0000, 32'h0001_0000, 1'b0);
        check("R2", "wrapped borrow", result, 32'hFFFF_0000);
        check("R3", "flag from unsaturated borrow", {31'b0, ovf_flag}, 32'd1);

        // R3: signed formats never set the flag.
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        issue(2'd2, 1'b0, 1'b0, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 1'b0);
        check("R6", "max positive halving", result, 32'h7FFF_7FFF);
        check("R3", "no flag from signed halving", {31'b0, ovf_flag}, 32'd0);

        // R10: reset mid-run clears everything.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R10", "result after reset", result, 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule